// File: doc/BRIEF.md
# Wakeup Interrupt Polarity Normalizer

This block sits between a bank of raw wake-capable interrupt lines and a downstream interrupt controller that only understands active-high levels and rising edges. Each line carries a three-bit sense code held in its own configuration word. The code selects how the line is interpreted. An active-low level is inverted into an active-high level. A falling edge becomes a one-cycle rising pulse. A dual-edge line yields a one-cycle pulse on every transition.

Every raw input first passes through a two-stage synchronizer. An edge detector follows, which compares the synchronized value against its value one cycle earlier. A registered output stage applies the sense code, the per-line enable bit, and a one-cycle blanking that hides any stray event caused by rewriting a code. Software reaches the block through a plain word-addressed register port. The enable bank packs 32 lines per word. Each line then has one configuration word of its own. Reads return data one cycle after the read strobe.

Top module: `wkn_normalizer`

## Requirements
- R1: Register map (byte addresses, 32-bit words). Enable word k lives at 0x10 + 4*k and bit b of it enables line 32*k + b. The configuration word of line i lives at 0x110 + 4*i and holds the sense code in bits [2:0]. A read strobe returns the addressed word on bus_rdata one cycle later. bus_rdata holds its value while no read is strobed. Bits with no storage behind them read as zero: enable bits of lines at or above N_LINES, configuration bits [31:3], and every unmapped address.
- R2: After reset every enable bit is 0, every sense code is 100 and every output is low.
- R3: With code 100 (level, active high) the output follows the input. With code 000 (level, active low) the output is the inverted input. A change on the input appears on the output on the third rising clock edge after it.
- R4: With code 110 (rising edge) a 0-to-1 input transition gives exactly one output cycle high, in the same slot as the level latency of R3. A 1-to-0 transition gives nothing.
- R5: With code 010 (falling edge) a 1-to-0 input transition gives exactly one output cycle high. A 0-to-1 transition gives nothing.
- R6: With code 111 (dual edge) each input transition, in either direction, gives one output cycle high.
- R7: A line whose enable bit is clear drives its output low. Its edge history keeps tracking the input, so transitions that happened while it was disabled produce no pulse once it is enabled.
- R8: The codes 001, 011 and 101 are undefined and hold the line's output low for any input.
- R9: A configuration write that changes a line's code forces that line's output low in the cycle after the write edge. A write of the code already stored leaves the output undisturbed.
- R10: Changing a line's code while its input stays steady never produces an edge pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_rd | input | 1 | Read strobe for the register port |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| irq_in | input | N_LINES | Raw interrupt lines, asynchronous |
| irq_out | output | N_LINES | Normalized lines: active-high levels or one-cycle rising pulses |

## Verification
An input change reaches irq_out on the third rising edge after the change: two synchronizer stages and the output register. The bench drives inputs on the falling edge and samples on the third falling edge after that. For an edge code it records a five-cycle window and expects the pulse in the third slot only. A register write takes effect at its own write edge, so the sample taken on the following falling edge shows the blanked or still-old output, and the new behaviour appears one cycle later. Read data is taken on the falling edge after the strobed rising edge. The random phase keeps a four-deep history of the driven inputs and checks every cycle against the history entries three and four cycles old.

// File: rtl/wkn_pkg.sv
package wkn_pkg;
  localparam int unsigned SENSE_W    = 3;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned EN_BASE    = 'h10;
  localparam int unsigned CFG_BASE   = 'h110;

  typedef enum logic [SENSE_W-1:0] {
    LVL_LO   = 3'b000,
    EDG_FALL = 3'b010,
    LVL_HI   = 3'b100,
    EDG_RISE = 3'b110,
    EDG_BOTH = 3'b111
  } sense_e;

  // cur: synchronized input now, prv: one cycle earlier
  function automatic logic sense_eval(logic [SENSE_W-1:0] code, logic cur, logic prv);
    case (code)
      LVL_HI:   return cur;
      LVL_LO:   return !cur;
      EDG_RISE: return cur && !prv;
      EDG_FALL: return !cur && prv;
      EDG_BOTH: return cur ^ prv;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/wkn_line.sv
module wkn_line
  import wkn_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               raw_in,
  input  logic               line_en,
  input  logic [SENSE_W-1:0] sense,
  input  logic               blank,
  output logic               norm_out
);
  logic meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= 1'b0;
      sync_q   <= 1'b0;
      hist_q   <= 1'b0;
      norm_out <= 1'b0;
    end else begin
      meta_q <= raw_in;
      sync_q <= meta_q;
      // history always follows the input, enabled or not
      hist_q <= sync_q;
      if (line_en && !blank) norm_out <= sense_eval(sense, sync_q, hist_q);
      else                   norm_out <= 1'b0;
    end
  end
endmodule

// File: rtl/wkn_regs.sv
module wkn_regs
  import wkn_pkg::*;
#(
  parameter int N_LINES = 168,
  parameter int ADDR_W  = 12
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [REG_W-1:0]           bus_wdata,
  output logic [REG_W-1:0]           bus_rdata,
  output logic [N_LINES-1:0]         line_en,
  output logic [N_LINES*SENSE_W-1:0] cfg_flat,
  output logic [N_LINES-1:0]         cfg_chg
);
  localparam int EN_WORDS = (N_LINES + REG_W - 1) / REG_W;

  function automatic logic [ADDR_W-1:0] en_addr(int w);
    return ADDR_W'(EN_BASE + w * WORD_BYTES);
  endfunction

  function automatic logic [ADDR_W-1:0] cfg_addr(int i);
    return ADDR_W'(CFG_BASE + i * WORD_BYTES);
  endfunction

  function automatic logic [REG_W-1:0] live_mask(int w);
    logic [REG_W-1:0] m;
    for (int b = 0; b < REG_W; b++) m[b] = ((w * REG_W + b) < N_LINES);
    return m;
  endfunction

  logic [EN_WORDS*REG_W-1:0] en_flat;
  logic [REG_W-1:0]          rd_word;

  for (genvar w = 0; w < EN_WORDS; w++) begin : g_en
    localparam logic [ADDR_W-1:0] WADDR = en_addr(w);
    localparam logic [REG_W-1:0]  WMASK = live_mask(w);
    logic [REG_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          word_q <= '0;
      else if (bus_wr && bus_addr == WADDR) word_q <= bus_wdata & WMASK;
    end
    assign en_flat[w*REG_W +: REG_W] = word_q;
  end

  assign line_en = en_flat[N_LINES-1:0];

  for (genvar i = 0; i < N_LINES; i++) begin : g_cfg
    localparam logic [ADDR_W-1:0] CADDR = cfg_addr(i);
    logic [SENSE_W-1:0] code_q;
    logic               hit;
    assign hit        = bus_wr && (bus_addr == CADDR);
    assign cfg_chg[i] = hit && (bus_wdata[SENSE_W-1:0] != code_q);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   code_q <= LVL_HI;
      else if (hit) code_q <= bus_wdata[SENSE_W-1:0];
    end
    assign cfg_flat[i*SENSE_W +: SENSE_W] = code_q;
  end

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < EN_WORDS; w++)
      if (bus_addr == en_addr(w)) rd_word = en_flat[w*REG_W +: REG_W];
    for (int i = 0; i < N_LINES; i++)
      if (bus_addr == cfg_addr(i)) rd_word = REG_W'(cfg_flat[i*SENSE_W +: SENSE_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end
endmodule

// File: rtl/wkn_normalizer.sv
module wkn_normalizer
  import wkn_pkg::*;
#(
  parameter int N_LINES = 168,
  parameter int ADDR_W  = 12
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [N_LINES-1:0] irq_in,
  output logic [N_LINES-1:0] irq_out
);
  logic [N_LINES-1:0]         line_en;
  logic [N_LINES*SENSE_W-1:0] cfg_flat;
  logic [N_LINES-1:0]         cfg_chg;

  wkn_regs #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .line_en   (line_en),
    .cfg_flat  (cfg_flat),
    .cfg_chg   (cfg_chg)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    wkn_line u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (irq_in[i]),
      .line_en  (line_en[i]),
      .sense    (cfg_flat[i*SENSE_W +: SENSE_W]),
      .blank    (cfg_chg[i]),
      .norm_out (irq_out[i])
    );
  end
endmodule

// File: rtl/wkn_checker.sv
module wkn_checker
  import wkn_pkg::*;
#(
  parameter int N_LINES = 168
)(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_rd,
  input logic [31:0]                bus_rdata,
  input logic [N_LINES-1:0]         line_en,
  input logic [N_LINES*SENSE_W-1:0] cfg_flat,
  input logic [N_LINES-1:0]         irq_out
);
  logic [N_LINES-1:0] rise_m, fall_m, bad_m;

  always_comb begin
    for (int i = 0; i < N_LINES; i++) begin
      rise_m[i] = (cfg_flat[i*SENSE_W +: SENSE_W] == 3'b110);
      fall_m[i] = (cfg_flat[i*SENSE_W +: SENSE_W] == 3'b010);
      bad_m[i]  = (cfg_flat[i*SENSE_W +: SENSE_W] == 3'b001) ||
                  (cfg_flat[i*SENSE_W +: SENSE_W] == 3'b011) ||
                  (cfg_flat[i*SENSE_W +: SENSE_W] == 3'b101);
    end
  end

  AST_RDATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R1
  AST_OFF_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~$past(line_en)) == '0); // R7
  AST_BAD_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & $past(bad_m)) == '0); // R8
  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & $past(irq_out) & $past(rise_m) & $past(rise_m, 2)) == '0); // R4
  AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & $past(irq_out) & $past(fall_m) & $past(fall_m, 2)) == '0); // R5
endmodule

bind wkn_normalizer wkn_checker #(.N_LINES(N_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .line_en   (line_en),
  .cfg_flat  (cfg_flat),
  .irq_out   (irq_out)
);

// File: tb/sim_wkn_normalizer.sv
module sim_wkn_normalizer;
  localparam int N  = 168;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  lines_in = '0;
  logic [N-1:0]  irq_out;

  int total = 0, bad = 0;
  logic [2:0] cfg_sh [N];
  logic [N-1:0] en_sh = '0;

  always #4 clk = ~clk;

  wkn_normalizer #(.N_LINES(N), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(lines_in), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic f_sense(logic [2:0] c, logic cur, logic prv);
    case (c)
      3'b100:  return cur;
      3'b000:  return !cur;
      3'b110:  return cur & ~prv;
      3'b010:  return ~cur & prv;
      3'b111:  return cur ^ prv;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [N-1:0] model(logic [N-1:0] cur, logic [N-1:0] prv);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = en_sh[i] & f_sense(cfg_sh[i], cur[i], prv[i]);
    return r;
  endfunction

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_cfg(input int line, input logic [2:0] c);
    cfg_sh[line] = c;
    bus_write(AW'(32'h110 + 4 * line), {29'h1ABCDEF0, c});
  endtask

  task automatic put_en_word(input int w);
    logic [31:0] word;
    for (int b = 0; b < 32; b++) word[b] = (w * 32 + b < N) ? en_sh[w * 32 + b] : 1'b1;
    bus_write(AW'(32'h10 + 4 * w), word);
  endtask

  task automatic set_en(input int line, input logic v);
    en_sh[line] = v;
    put_en_word(line / 32);
  endtask

  task automatic drive(input int line, input logic v);
    @(negedge clk);
    lines_in[line] = v;
  endtask

  task automatic watch(input int line, output logic [4:0] pat);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      pat[k] = irq_out[line];
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [4:0]  pat;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) cfg_sh[i] = 3'b100;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(2);

    // R2 reset state
    check("R2 outputs low", 256'(irq_out), 256'(0));
    bus_read(12'h010, rd); check("R2 enable word reset", 256'(rd), 256'(0));
    bus_read(12'h124, rd); check("R2 code reset level-high", 256'(rd), 256'(4));

    // R1 register map and unused bits
    bus_write(12'h014, 32'hFFFF_FFFF);
    bus_read(12'h014, rd); check("R1 enable word 1", 256'(rd), 256'(32'hFFFF_FFFF));
    bus_write(12'h024, 32'hFFFF_FFFF);
    bus_read(12'h024, rd); check("R1 enable word 5 only lines below 168", 256'(rd), 256'(32'h0000_00FF));
    bus_write(12'h3AC, 32'hFFFF_FFF6);
    bus_read(12'h3AC, rd); check("R1 code of line 167 bits 2:0", 256'(rd), 256'(6));
    bus_read(12'h008, rd); check("R1 unmapped reads zero", 256'(rd), 256'(0));
    wait_n(3);
    check("R1 rdata holds without read strobe", 256'(bus_rdata), 256'(0));
    bus_write(12'h014, 32'h0); bus_write(12'h024, 32'h0);
    set_cfg(167, 3'b100);
    wait_n(4);

    // R3 level modes, latency, and line-to-bit mapping of R1
    set_en(37, 1'b1); set_en(160, 1'b1);
    wait_n(2);
    drive(37, 1'b1);
    wait_n(2);
    check("R3 level not yet visible after two edges", 256'(irq_out), 256'(0));
    wait_n(1);
    check("R3 level visible on third edge line 37", 256'(irq_out), 256'(1) << 37);
    drive(160, 1'b1); wait_n(4);
    check("R1 R3 line 160 via enable word 5", 256'(irq_out), (256'(1) << 37) | (256'(1) << 160));
    set_en(160, 1'b0); drive(160, 1'b0);
    set_cfg(37, 3'b000); wait_n(4);
    check("R3 active-low with input high", 256'(irq_out[37]), 256'(0));
    drive(37, 1'b0); wait_n(4);
    check("R3 active-low with input low", 256'(irq_out[37]), 256'(1));

    // R4 rising edge
    set_cfg(37, 3'b110); wait_n(4);
    drive(37, 1'b1); watch(37, pat);
    check("R4 rising pulse one cycle", 256'(pat), 256'(5'b00100));
    drive(37, 1'b0); watch(37, pat);
    check("R4 falling transition ignored", 256'(pat), 256'(0));

    // R5 falling edge
    set_cfg(37, 3'b010); wait_n(4);
    drive(37, 1'b1); watch(37, pat);
    check("R5 rising transition ignored", 256'(pat), 256'(0));
    drive(37, 1'b0); watch(37, pat);
    check("R5 falling pulse one cycle", 256'(pat), 256'(5'b00100));

    // R6 dual edge
    set_cfg(37, 3'b111); wait_n(4);
    drive(37, 1'b1); watch(37, pat);
    check("R6 pulse on rise", 256'(pat), 256'(5'b00100));
    drive(37, 1'b0); watch(37, pat);
    check("R6 pulse on fall", 256'(pat), 256'(5'b00100));

    // R8 undefined code
    set_cfg(37, 3'b001); wait_n(4);
    check("R8 undefined code low with input low", 256'(irq_out[37]), 256'(0));
    drive(37, 1'b1); watch(37, pat);
    check("R8 undefined code low after rise", 256'(pat), 256'(0));
    set_cfg(37, 3'b101); drive(37, 1'b0); watch(37, pat);
    check("R8 undefined code low after fall", 256'(pat), 256'(0));

    // R7 disabled line, history tracking
    set_cfg(37, 3'b100); drive(37, 1'b1); wait_n(4);
    check("R7 enabled level reference", 256'(irq_out[37]), 256'(1));
    set_en(37, 1'b0); wait_n(1);
    check("R7 disabled line low", 256'(irq_out[37]), 256'(0));
    set_cfg(37, 3'b110); drive(37, 1'b0); wait_n(4);
    drive(37, 1'b1); wait_n(5);
    set_en(37, 1'b1); watch(37, pat);
    check("R7 no pulse from transition while disabled", 256'(pat), 256'(0));

    // R9 blanking on code change, none on same-code write
    set_cfg(37, 3'b100); wait_n(4);
    check("R9 level reference high", 256'(irq_out[37]), 256'(1));
    set_cfg(37, 3'b100);
    check("R9 same-code write leaves output high", 256'(irq_out[37]), 256'(1));
    set_cfg(37, 3'b000); set_cfg(37, 3'b100);
    check("R9 changed code blanks output", 256'(irq_out[37]), 256'(0));
    wait_n(1);
    check("R9 output returns after blank", 256'(irq_out[37]), 256'(1));
    set_cfg(37, 3'b111);
    check("R9 change to dual blanks output", 256'(irq_out[37]), 256'(0));

    // R10 steady input, code changes give no pulse
    watch(37, pat); check("R10 no pulse after level to dual", 256'(pat), 256'(0));
    set_cfg(37, 3'b110); watch(37, pat);
    check("R10 no pulse after dual to rising", 256'(pat), 256'(0));
    set_cfg(37, 3'b010); watch(37, pat);
    check("R10 no pulse after rising to falling", 256'(pat), 256'(0));

    // random rounds for R3 R4 R5 R6 R7 R8
    for (int round = 0; round < 3; round++) begin
      logic [N-1:0] d1, d2, d3, d4, nx, t1, t2;
      for (int i = 0; i < N; i++) begin
        case ($urandom % 6)
          0: set_cfg(i, 3'b000);
          1: set_cfg(i, 3'b010);
          2: set_cfg(i, 3'b100);
          3: set_cfg(i, 3'b110);
          4: set_cfg(i, 3'b111);
          default: set_cfg(i, 3'b011);
        endcase
      end
      for (int i = 0; i < N; i++) en_sh[i] = ($urandom % 4) != 0;
      for (int w = 0; w < (N + 31) / 32; w++) put_en_word(w);
      for (int i = 0; i < N; i++) lines_in[i] = $urandom % 2;
      wait_n(6);
      d1 = lines_in; d2 = lines_in; d3 = lines_in; d4 = lines_in;
      for (int cyc = 0; cyc < 150; cyc++) begin
        @(negedge clk);
        check("random R3 R4 R5 R6 R7 R8", 256'(irq_out), 256'(model(d3, d4)));
        for (int i = 0; i < N; i++) begin
          t1[i] = $urandom % 2;
          t2[i] = $urandom % 2;
        end
        nx = d1 ^ (t1 & t2);
        lines_in = nx;
        d4 = d3; d3 = d2; d2 = d1; d1 = nx;
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule